// File: doc/BRIEF.md
# Quad DAC serial register interface

This block is a synthesizable model of the digital control side of a four-channel digital-to-analog converter. A host writes it through a three-wire serial link: an active-low frame select, a serial clock and a data line. A separate active-low load strobe is also provided. All four pins are brought into the fast system clock domain, and their edges are detected there. Each frame fills a 24-bit shift register. When the frame select is released, a command decoder acts on the register contents.

Each channel has two tiers of registers. An input register holds a staged value. A DAC register holds the value driven to the converter. Values move from the first tier to the second on a command, on a direct write, or when the load strobe is asserted. A software-set chaining flag routes bits shifted out of the register to a serial output. Several such blocks can then be cascaded in one long frame.

Top module: `qdac_serial_if`

## Requirements
- R1: While `sync_n` is low, each falling edge of `sclk` shifts `sdin` into bit 0 of the 24-bit shift register, and older bits move one place up. The register is read with the command in bits [23:20], a channel mask in bits [19:16] (bit 16 = channel 0 through bit 19 = channel 3) and data in bits [15:0].
- R2: The command executes once, on the rising edge of `sync_n`, using the current register contents. This holds for any frame length. A short frame keeps the older bits, and a long frame keeps only the last 24 bits.
- R3: Command 0x1 loads the data into the input register of every channel whose mask bit is set. While `ldac_n` is high, the DAC registers do not change.
- R4: If `ldac_n` is low when command 0x1 executes, each addressed DAC register also takes the data.
- R5: Command 0x2 copies the input register of every addressed channel into its DAC register.
- R6: Command 0x3 writes the data into the DAC register of every addressed channel. It does this whatever the state of `ldac_n`, and it leaves the input registers unchanged.
- R7: Command 0x8 sets the chaining flag to data bit 0. The flag is 0 after reset.
- R8: While `ldac_n` is low and `sync_n` is high, every DAC register loads from its input register.
- R9: With the chaining flag set, `sdo` takes shift-register bit 23 at the falling edge of `sync_n` and at each rising edge of `sclk` inside a frame. The first bit of a frame therefore appears on `sdo` after 24 clocks.
- R10: `sclk` edges while `sync_n` is high leave the shift register unchanged. With the chaining flag clear, `sdo` is held low.
- R11: Command codes other than 0x1, 0x2, 0x3 and 0x8 change no register. Reset clears all registers and outputs to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample all serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_n | input | 1 | Active-low frame select; its rising edge executes the command |
| sclk | input | 1 | Serial clock; data is shifted on its falling edge |
| sdin | input | 1 | Serial data in, most significant bit first |
| ldac_n | input | 1 | Active-low load strobe for the DAC registers |
| sdo | output | 1 | Serial data out in chaining mode, low otherwise |
| dac_q | output | 4x16 | DAC register values, channel 0 in the lowest slice |

## Verification
The properties assume the serial pins change slowly against the system clock. They also assume that a falling `sclk` edge and a `sync_n` edge never land in the same sampled cycle. Under those conditions every edge is seen exactly once, and every command is decoded from a settled register. The stimulus holds each pin level for four system clocks. It waits at least that long between `sync_n` edges and clock edges, and it changes `ldac_n` only inside a frame or as an isolated pulse while `sync_n` is high. Random frames vary the command, the channel mask, the data, the length (including empty and over-long frames) and the `ldac_n` level.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
   localparam int CMD_W = 4;

   typedef enum logic [CMD_W-1:0] {
      CMD_NOP     = 4'h0,
      CMD_WR_IN   = 4'h1,
      CMD_UPDATE  = 4'h2,
      CMD_WR_DAC  = 4'h3,
      CMD_CHAIN   = 4'h8
   } qdac_cmd_e;
endpackage

// File: rtl/qdac_insync.sv
module qdac_insync #(
   parameter int             STAGES  = 2,
   parameter int             WIDTH   = 4,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] pin_i,
   output logic [WIDTH-1:0] lvl_o,
   output logic [WIDTH-1:0] rise_o,
   output logic [WIDTH-1:0] fall_o
);
   localparam int CHAIN_W = STAGES * WIDTH;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("qdac_insync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("qdac_insync: WIDTH must be at least 1");
      end
   endgenerate

   logic [CHAIN_W-1:0] chain_q;
   logic [WIDTH-1:0]   prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= {STAGES{RST_VAL}};
         prev_q  <= RST_VAL;
      end else begin
         chain_q <= {chain_q[CHAIN_W-WIDTH-1:0], pin_i};
         prev_q  <= chain_q[CHAIN_W-1 -: WIDTH];
      end
   end

   assign lvl_o  = chain_q[CHAIN_W-1 -: WIDTH];
   assign rise_o = lvl_o & ~prev_q;
   assign fall_o = ~lvl_o & prev_q;
endmodule

// File: rtl/qdac_shifter.sv
module qdac_shifter #(
   parameter int FRAME_BITS = 24
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  shift_en,
   input  logic                  ser_bit,
   input  logic                  out_load,
   input  logic                  chain_en,
   output logic [FRAME_BITS-1:0] sr_q,
   output logic                  sdo_q
);
   generate
      if (FRAME_BITS < 2) begin : g_bad_frame
         $error("qdac_shifter: FRAME_BITS must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q <= '0;
      end else if (shift_en) begin
         sr_q <= {sr_q[FRAME_BITS-2:0], ser_bit};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sdo_q <= 1'b0;
      end else if (!chain_en) begin
         sdo_q <= 1'b0;
      end else if (out_load) begin
         sdo_q <= sr_q[FRAME_BITS-1];
      end
   end
endmodule

// File: rtl/qdac_regbank.sv
module qdac_regbank
   import qdac_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int DATA_W = 16
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           exec,
   input  logic                           load_all,
   input  logic                           ldac_low,
   input  logic [CMD_W-1:0]               cmd,
   input  logic [NUM_CH-1:0]              addr,
   input  logic [DATA_W-1:0]              data,
   output logic [NUM_CH-1:0][DATA_W-1:0]  in_q,
   output logic [NUM_CH-1:0][DATA_W-1:0]  dac_q,
   output logic                           chain_q
);
   logic is_wr_in;
   logic is_update;
   logic is_wr_dac;
   logic is_chain;

   always_comb begin
      is_wr_in  = exec && (cmd == CMD_WR_IN);
      is_update = exec && (cmd == CMD_UPDATE);
      is_wr_dac = exec && (cmd == CMD_WR_DAC);
      is_chain  = exec && (cmd == CMD_CHAIN);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= 1'b0;
      end else if (is_chain) begin
         chain_q <= data[0];
      end
   end

   generate
      if (NUM_CH < 1 || DATA_W < 1) begin : g_bad_bank
         $error("qdac_regbank: NUM_CH and DATA_W must be positive");
      end
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         logic in_we;
         logic dac_we;
         logic [DATA_W-1:0] dac_nxt;

         always_comb begin
            in_we   = is_wr_in && addr[c];
            dac_we  = 1'b0;
            dac_nxt = dac_q[c];
            if (addr[c] && (is_wr_dac || (is_wr_in && ldac_low))) begin
               dac_we  = 1'b1;
               dac_nxt = data;
            end else if (addr[c] && is_update) begin
               dac_we  = 1'b1;
               dac_nxt = in_q[c];
            end else if (load_all) begin
               dac_we  = 1'b1;
               dac_nxt = in_q[c];
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               in_q[c] <= '0;
            end else if (in_we) begin
               in_q[c] <= data;
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               dac_q[c] <= '0;
            end else if (dac_we) begin
               dac_q[c] <= dac_nxt;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/qdac_serial_if.sv
module qdac_serial_if
   import qdac_pkg::*;
#(
   parameter int NUM_CH      = 4,
   parameter int DATA_W      = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          sync_n,
   input  logic                          sclk,
   input  logic                          sdin,
   input  logic                          ldac_n,
   output logic                          sdo,
   output logic [NUM_CH-1:0][DATA_W-1:0] dac_q
);
   localparam int FRAME_BITS = CMD_W + NUM_CH + DATA_W;
   localparam int ADDR_LSB   = DATA_W;
   localparam int CMD_LSB    = DATA_W + NUM_CH;
   localparam int PIN_W      = 4;
   localparam int P_SYNC     = 0;
   localparam int P_SCLK     = 1;
   localparam int P_SDIN     = 2;
   localparam int P_LDAC     = 3;
   localparam logic [PIN_W-1:0] PIN_IDLE = 4'b1011;

   logic [PIN_W-1:0] pin_lvl;
   logic [PIN_W-1:0] pin_rise;
   logic [PIN_W-1:0] pin_fall;

   qdac_insync #(
      .STAGES  (SYNC_STAGES),
      .WIDTH   (PIN_W),
      .RST_VAL (PIN_IDLE)
   ) u_insync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  ({ldac_n, sdin, sclk, sync_n}),
      .lvl_o  (pin_lvl),
      .rise_o (pin_rise),
      .fall_o (pin_fall)
   );

   logic sync_hi;
   logic frame_start;
   logic frame_end;
   logic shift_en;
   logic out_load;
   logic load_all;
   logic ldac_low;
   logic chain_en;
   logic [FRAME_BITS-1:0] sr_q;
   logic [NUM_CH-1:0][DATA_W-1:0] in_q;

   always_comb begin
      sync_hi     = pin_lvl[P_SYNC];
      frame_start = pin_fall[P_SYNC];
      frame_end   = pin_rise[P_SYNC];
      ldac_low    = ~pin_lvl[P_LDAC];
      shift_en    = pin_fall[P_SCLK] & ~sync_hi;
      out_load    = (pin_rise[P_SCLK] & ~sync_hi) | frame_start;
      load_all    = ldac_low & sync_hi & ~frame_end;
   end

   qdac_shifter #(
      .FRAME_BITS (FRAME_BITS)
   ) u_shifter (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (shift_en),
      .ser_bit  (pin_lvl[P_SDIN]),
      .out_load (out_load),
      .chain_en (chain_en),
      .sr_q     (sr_q),
      .sdo_q    (sdo)
   );

   qdac_regbank #(
      .NUM_CH (NUM_CH),
      .DATA_W (DATA_W)
   ) u_regbank (
      .clk      (clk),
      .rst_n    (rst_n),
      .exec     (frame_end),
      .load_all (load_all),
      .ldac_low (ldac_low),
      .cmd      (sr_q[CMD_LSB +: CMD_W]),
      .addr     (sr_q[ADDR_LSB +: NUM_CH]),
      .data     (sr_q[DATA_W-1:0]),
      .in_q     (in_q),
      .dac_q    (dac_q),
      .chain_q  (chain_en)
   );
endmodule

// File: rtl/qdac_chk.sv
module qdac_chk #(
   parameter int NUM_CH     = 4,
   parameter int DATA_W     = 16,
   parameter int FRAME_BITS = 24
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          exec,
   input logic                          load_all,
   input logic                          sync_hi,
   input logic                          out_load,
   input logic                          chain_en,
   input logic                          sdo,
   input logic [FRAME_BITS-1:0]         sr_q,
   input logic [NUM_CH-1:0][DATA_W-1:0] in_q,
   input logic [NUM_CH-1:0][DATA_W-1:0] dac_q
);
   localparam int ADDR_LSB = DATA_W;
   localparam int CMD_LSB  = DATA_W + NUM_CH;

   // R10
   sr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sync_hi |=> $stable(sr_q));

   // R10
   sdo_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !chain_en |=> !sdo);

   // R9
   sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chain_en && !out_load) |=> $stable(sdo));

   // R11
   regs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!exec && !load_all) |=> ($stable(dac_q) && $stable(in_q)));

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
         // R8
         load_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
            load_all |=> (dac_q[c] == $past(in_q[c])));

         // R6
         direct_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (exec && sr_q[CMD_LSB +: 4] == 4'h3 && sr_q[ADDR_LSB + c])
            |=> (dac_q[c] == $past(sr_q[DATA_W-1:0])) && $stable(in_q[c]));
      end
   endgenerate
endmodule

bind qdac_serial_if qdac_chk #(
   .NUM_CH     (NUM_CH),
   .DATA_W     (DATA_W),
   .FRAME_BITS (FRAME_BITS)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .exec     (frame_end),
   .load_all (load_all),
   .sync_hi  (sync_hi),
   .out_load (out_load),
   .chain_en (chain_en),
   .sdo      (sdo),
   .sr_q     (sr_q),
   .in_q     (in_q),
   .dac_q    (dac_q)
);

// File: tb/tb_qdac_serial_if.sv
module tb_qdac_serial_if;
   localparam int NCH = 4;
   localparam int DW  = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sync_n = 1'b1;
   logic sclk = 1'b1;
   logic sdin = 1'b0;
   logic ldac_n = 1'b1;
   logic sdo;
   logic [NCH-1:0][DW-1:0] dac_q;

   int n_chk = 0;
   int n_bad = 0;

   logic [DW-1:0] m_in  [NCH];
   logic [DW-1:0] m_dac [NCH];
   logic          m_chain;
   logic [23:0]   m_sr;

   always #4 clk = ~clk;

   qdac_serial_if dut (
      .clk    (clk),
      .rst_n  (rst_n),
      .sync_n (sync_n),
      .sclk   (sclk),
      .sdin   (sdin),
      .ldac_n (ldac_n),
      .sdo    (sdo),
      .dac_q  (dac_q)
   );

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic check_dacs(input string req);
      for (int c = 0; c < NCH; c++) check(req, 32'(dac_q[c]), 32'(m_dac[c]));
   endtask

   // expected effect of the command held in m_sr at the end of a frame
   function automatic void model_exec(input logic ldac_low);
      logic [3:0]    cmd;
      logic [3:0]    addr;
      logic [DW-1:0] data;
      cmd  = m_sr[23:20];
      addr = m_sr[19:16];
      data = m_sr[15:0];
      for (int c = 0; c < NCH; c++) begin
         if (addr[c]) begin
            case (cmd)
               4'h1: begin m_in[c] = data; if (ldac_low) m_dac[c] = data; end
               4'h2: m_dac[c] = m_in[c];
               4'h3: m_dac[c] = data;
               default: ;
            endcase
         end
      end
      if (cmd == 4'h8) m_chain = data[0];
      if (ldac_low) for (int c = 0; c < NCH; c++) m_dac[c] = m_in[c];
   endfunction

   // send the n lowest bits of v, most significant first
   task automatic send(input logic [63:0] v, input int n, input logic ldac_low);
      sync_n = 1'b0;
      wait_n(4);
      if (ldac_low) ldac_n = 1'b0;
      for (int i = n - 1; i >= 0; i--) begin
         sclk = 1'b1;
         sdin = v[i];
         wait_n(4);
         if (m_chain) check("R9 sdo ripple", 32'(sdo), 32'(m_sr[23]));
         else         check("R10 sdo standalone", 32'(sdo), 32'h0);
         sclk = 1'b0;
         wait_n(4);
         m_sr = {m_sr[22:0], v[i]};
      end
      sclk = 1'b1;
      wait_n(4);
      sync_n = 1'b1;
      wait_n(6);
      model_exec(ldac_low);
      ldac_n = 1'b1;
      wait_n(4);
   endtask

   task automatic word(input logic [3:0] cmd, input logic [3:0] addr,
                       input logic [15:0] data, input logic ldac_low);
      send({40'h0, cmd, addr, data}, 24, ldac_low);
   endtask

   task automatic ldac_pulse();
      ldac_n = 1'b0;
      wait_n(6);
      ldac_n = 1'b1;
      wait_n(4);
      for (int c = 0; c < NCH; c++) m_dac[c] = m_in[c];
   endtask

   initial begin
      wait_n(190000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      int unsigned seed;
      seed = 32'd20240611;
      void'($urandom(seed));
      for (int c = 0; c < NCH; c++) begin m_in[c] = '0; m_dac[c] = '0; end
      m_chain = 1'b0;
      m_sr = '0;
      wait_n(5);
      // R11 reset state
      check_dacs("R11 reset");
      check("R11 reset sdo", 32'(sdo), 32'h0);
      rst_n = 1'b1;
      wait_n(5);

      // R1 R6 direct write, input register untouched
      word(4'h3, 4'b0001, 16'h1234, 1'b0);
      check_dacs("R6 direct write");
      word(4'h2, 4'b0001, 16'h0000, 1'b0);
      check("R6 input untouched", 32'(dac_q[0]), 32'h0);
      // R3 staged write, R5 update
      word(4'h1, 4'b0010, 16'hBEEF, 1'b0);
      check("R3 dac held", 32'(dac_q[1]), 32'h0);
      word(4'h2, 4'b0010, 16'h0000, 1'b0);
      check("R5 update", 32'(dac_q[1]), 32'hBEEF);
      // R4 transparent write to two channels
      word(4'h1, 4'b1100, 16'h5555, 1'b1);
      check_dacs("R4 transparent");
      // R8 load strobe with frame select high
      word(4'h1, 4'b0001, 16'h0A0A, 1'b0);
      check("R3 staged A", 32'(dac_q[0]), 32'h0);
      ldac_pulse();
      check_dacs("R8 load pulse");
      // R11 unknown command
      word(4'h7, 4'b1111, 16'hFFFF, 1'b0);
      check_dacs("R11 no-op");
      // R2 short and long frames
      word(4'h3, 4'b0001, 16'h3C12, 1'b0);
      send(64'h0, 4, 1'b0);
      check_dacs("R2 short frame");
      send({32'h0, 4'hF, 4'h3, 4'b0100, 16'h7E57}, 28, 1'b0);
      check_dacs("R2 long frame");
      send(64'h0, 0, 1'b0);
      check_dacs("R2 empty frame");

      // R7 chaining on, R9 ripple across a double frame
      word(4'h8, 4'b0000, 16'h0001, 1'b0);
      send({16'h0, 24'h3_8_CAFE, 24'h3_2_F00D}, 48, 1'b0);
      check_dacs("R9 chain frame");
      // R10 clock toggles while frame select is high
      for (int i = 0; i < 10; i++) begin
         sdin = i[0];
         sclk = 1'b0; wait_n(4);
         sclk = 1'b1; wait_n(4);
      end
      send(64'h0, 0, 1'b0);
      check_dacs("R10 ignored clocks");
      word(4'h8, 4'b0000, 16'h0000, 1'b0);
      check("R7 chain off sdo", 32'(sdo), 32'h0);

      // random frames
      for (int k = 0; k < 160; k++) begin
         logic [3:0]  cmd;
         logic [63:0] v;
         int          len;
         int unsigned r;
         r = $urandom % 6;
         case (r)
            0: cmd = 4'h1; 1: cmd = 4'h2; 2: cmd = 4'h3;
            3: cmd = 4'h8; 4: cmd = 4'h1; default: cmd = 4'($urandom);
         endcase
         v = {$urandom, $urandom};
         v[23:20] = cmd;
         len = ($urandom % 5 == 0) ? int'($urandom % 41) : 24;
         if (len > 24) v = {v[39:0], 24'($urandom)} >> 0;
         if (len > 24) v[23:20] = cmd;
         send(v, len, 1'($urandom % 3 == 0));
         check_dacs("R2 R3 R4 R5 R6 R11 random");
         if ($urandom % 8 == 0) begin
            ldac_pulse();
            check_dacs("R8 random pulse");
         end
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule